// File: doc/BRIEF.md
# Triggered Delay-and-Width Pulse Generator

This block turns each rising edge on an asynchronous trigger input into one output pulse. After the trigger is seen, the block waits a programmed number of time-base ticks, then drives the pulse output high for a second programmed number of ticks. The time base is either an internal tick, divided down from the system clock (one microsecond at the default setting), or the rising edges of an external, asynchronous clock input. Software sets the delay, the width, the time-base choice and the interrupt source through a small write-only register port.

The interrupt output is a one-cycle strobe. It can mark the accepted trigger, the start of the output pulse or the end of the output pulse. A trigger that arrives while a delay or a pulse is in progress is dropped, and the run that is underway is not disturbed.

Top module: `trig_pulse_gen`

## Requirements
- R1: While rst_ni is low and after its release, pulse_o and irq_o are 0 and the block is idle.
- R2: A write with wr_en_i high stores wr_data_i. Address 0 holds the 16-bit delay, address 1 holds the 16-bit width, and address 2 holds the control bits. In the control register, bit 0 selects the time base (0 for the internal tick, 1 for the external clock) and bits 2:1 select the interrupt source.
- R3: trig_i passes through a two-flop synchronizer. Only a rising edge is accepted, and only while the block is idle. Acceptance takes place on the third clock edge after trig_i is first sampled high.
- R4: With delay D, pulse_o rises on the (D+1)th time-base tick after acceptance. For D=0 this is the first tick after acceptance.
- R5: With width W≥1, pulse_o stays high for exactly W time-base ticks. Under the internal time base this equals W·TICK_DIV clock cycles.
- R6: A width of 0 produces no pulse, and the block returns to idle at once.
- R7: The internal tick fires once every TICK_DIV clock cycles. The external tick is each rising edge of ext_clk_i after a two-flop synchronizer, so an output edge follows an external edge by three clock cycles. Whichever time base is not selected has no effect.
- R8: A trigger that arrives during the delay or the pulse is ignored. It produces no extra pulse, no interrupt and no change in timing.
- R9: Delay and width are captured when a trigger is accepted. Writes made during a run do not change that run.
- R10: Interrupt source code 00 fires irq_o in the cycle the trigger is accepted. Code 01 fires it in the cycle pulse_o rises, and code 10 in the cycle pulse_o falls. Code 11 never fires it.
- R11: irq_o is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Asynchronous trigger |
| ext_clk_i | input | 1 | Asynchronous external time base |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 16 | Register write data |
| pulse_o | output | 1 | Generated pulse |
| irq_o | output | 1 | One-cycle interrupt strobe |

## Verification
The hardest case to reach from the ports is a trigger, or a register write, that lands while the machine is held at a chosen point inside a delay or a pulse. With the internal prescaler free running, the tick phase cannot be seen from outside. The bench therefore selects the external time base and supplies each external edge itself. This lets it park the machine in the delay or in the pulse, deliver a second trigger or rewrite the delay and width, and then count external edges up to the output edges. Every delay, width and interrupt-source combination of a small configuration is swept under both time bases.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_PULSE = 2'd2
  } tpg_state_e;

  // interrupt source codes
  localparam logic [1:0] IRQ_TRIG = 2'b00;
  localparam logic [1:0] IRQ_RISE = 2'b01;
  localparam logic [1:0] IRQ_FALL = 2'b10;

  localparam logic [1:0] ADDR_DELAY = 2'd0;
  localparam logic [1:0] ADDR_WIDTH = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;
endpackage

// File: rtl/tpg_sync_rise.sv
module tpg_sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R3
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tpg_tick.sv
module tpg_tick #(
  parameter int DIV = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + CW'(1);
      end

      assign tick_o = (cnt_q == LAST);

      // R7
      tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/tpg_cfg.sv
module tpg_cfg
  import tpg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] delay_o,
  output logic [CNT_W-1:0] width_o,
  output logic             ext_sel_o,
  output logic [1:0]       irq_sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      delay_o   <= '0;
      width_o   <= '0;
      ext_sel_o <= 1'b0;
      irq_sel_o <= 2'b11;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_DELAY: delay_o <= wr_data_i;
        ADDR_WIDTH: width_o <= wr_data_i;
        ADDR_CTRL: begin
          ext_sel_o <= wr_data_i[0];
          irq_sel_o <= wr_data_i[2:1];
        end
        default: ;
      endcase
    end
  end

  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(delay_o) && $stable(width_o) && $stable(irq_sel_o));
endmodule

// File: rtl/tpg_core.sv
module tpg_core
  import tpg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [1:0]       irq_sel_i,
  output logic             pulse_o,
  output logic             irq_o
);
  tpg_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] wid_q, wid_d;
  logic             irq_q, irq_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wid_d   = wid_q;
    irq_d   = 1'b0;
    case (state_q)
      ST_IDLE: if (trig_i) begin
        irq_d = (irq_sel_i == IRQ_TRIG);
        if (width_i != '0) begin
          state_d = ST_DELAY;
          cnt_d   = delay_i;
          wid_d   = width_i;
        end
      end
      ST_DELAY: if (tick_i) begin
        if (cnt_q == '0) begin
          state_d = ST_PULSE;
          cnt_d   = wid_q - CNT_W'(1);
          irq_d   = (irq_sel_i == IRQ_RISE);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_PULSE: if (tick_i) begin
        if (cnt_q == '0) begin
          state_d = ST_IDLE;
          irq_d   = (irq_sel_i == IRQ_FALL);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wid_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wid_q   <= wid_d;
      irq_q   <= irq_d;
    end
  end

  assign pulse_o = (state_q == ST_PULSE);
  assign irq_o   = irq_q;

  // R4
  rise_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(tick_i) && $past(state_q == ST_DELAY));
  // R5
  fall_on_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> $past(tick_i) && $past(cnt_q) == '0);
  // R6
  zero_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && trig_i && width_i == '0) |=> state_q == ST_IDLE);
  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !tick_i) |=> $stable(cnt_q) && $stable(state_q));
  // R9
  width_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PULSE) |-> cnt_q < wid_q);
  // R11
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen #(
  parameter int CNT_W       = 16,
  parameter int TICK_DIV    = 250,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             ext_clk_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pulse_o,
  output logic             irq_o
);
  logic             trig_rise, ext_rise, int_tick, tick;
  logic [CNT_W-1:0] delay, width;
  logic             ext_sel;
  logic [1:0]       irq_sel;

  tpg_sync_rise #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(trig_i), .rise_o(trig_rise));

  tpg_sync_rise #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ext_clk_i), .rise_o(ext_rise));

  tpg_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(int_tick));

  tpg_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .delay_o(delay), .width_o(width),
    .ext_sel_o(ext_sel), .irq_sel_o(irq_sel));

  assign tick = ext_sel ? ext_rise : int_tick;

  tpg_core #(.CNT_W(CNT_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_rise), .tick_i(tick),
    .delay_i(delay), .width_i(width), .irq_sel_i(irq_sel),
    .pulse_o(pulse_o), .irq_o(irq_o));

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |=> !pulse_o && !irq_o);
endmodule

// File: tb/trig_pulse_gen_tb.sv
module trig_pulse_gen_tb_top;
  localparam int DIV = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trig_i = 1'b0;
  logic        ext_clk_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        pulse_o, irq_o;

  trig_pulse_gen #(.CNT_W(16), .TICK_DIV(DIV), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .ext_clk_i(ext_clk_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pulse_o(pulse_o), .irq_o(irq_o));

  always #2 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  int pcyc = 0, t0 = 0, ext_edges = 0;
  int rise_at, fall_at, irq_at, rise_cnt, fall_cnt, irq_cnt, rise_e, fall_e;
  logic prev_p = 1'b0;

  always @(posedge clk_i) pcyc <= pcyc + 1;

  always @(negedge clk_i) begin
    if (pulse_o && !prev_p) begin rise_at = pcyc - t0; rise_cnt++; rise_e = ext_edges; end
    if (!pulse_o && prev_p) begin fall_at = pcyc - t0; fall_cnt++; fall_e = ext_edges; end
    if (irq_o) begin irq_at = pcyc - t0; irq_cnt++; end
    prev_p = pulse_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = 16'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic clear_mon();
    rise_at = -1; fall_at = -1; irq_at = -1;
    rise_cnt = 0; fall_cnt = 0; irq_cnt = 0; rise_e = -1; fall_e = -1;
    ext_edges = 0;
  endtask

  task automatic fire();
    @(negedge clk_i);
    trig_i = 1'b1; t0 = pcyc;
    cyc(3);
    trig_i = 1'b0;
  endtask

  task automatic ext_edge();
    @(negedge clk_i);
    ext_clk_i = 1'b1; ext_edges++;
    cyc(4);
    ext_clk_i = 1'b0;
    cyc(3);
  endtask

  task automatic retrig();
    @(negedge clk_i); trig_i = 1'b1;
    cyc(3); trig_i = 1'b0;
    cyc(3);
  endtask

  task automatic chk_irq(input int sel, input int w, input string tag);
    int exp_cnt, exp_at;
    exp_cnt = 0; exp_at = -1;
    if (sel == 0) begin exp_cnt = 1; exp_at = 3; end
    else if (sel == 1 && w > 0) begin exp_cnt = 1; exp_at = rise_at; end
    else if (sel == 2 && w > 0) begin exp_cnt = 1; exp_at = fall_at; end
    chk(irq_cnt == exp_cnt, {tag, " R10 irq count R11"}, irq_cnt, exp_cnt);
    if (exp_cnt == 1) chk(irq_at == exp_at, {tag, " R10 irq cycle"}, irq_at, exp_at);
  endtask

  initial begin
    cyc(3);
    chk(pulse_o == 1'b0 && irq_o == 1'b0, "R1 reset outputs", {pulse_o, irq_o}, 0);
    rst_ni = 1'b1;
    cyc(3);
    chk(pulse_o == 1'b0 && irq_o == 1'b0, "R1 after release", {pulse_o, irq_o}, 0);

    // internal time base sweep (R2 R3 R4 R5 R6 R7)
    for (int sel = 0; sel < 4; sel++)
      for (int d = 0; d < 4; d++)
        for (int w = 0; w < 4; w++) begin
          wr(2'd0, d); wr(2'd1, w); wr(2'd2, sel << 1);
          cyc(2);
          clear_mon();
          fire();
          cyc((d + w + 2) * DIV + 10);
          chk(rise_cnt == (w > 0 ? 1 : 0), "R6 int pulse count", rise_cnt, w > 0);
          if (w > 0) begin
            chk(rise_at >= 4 * d + 4 && rise_at <= 4 * d + 7, "R4 int delay", rise_at, 4 * d + 4);
            chk(fall_at - rise_at == w * DIV, "R5 int width R7", fall_at - rise_at, w * DIV);
          end
          chk_irq(sel, w, "int");
        end

    // external time base sweep with retriggers (R3 R4 R5 R7 R8)
    for (int sel = 0; sel < 4; sel++)
      for (int d = 0; d < 4; d++)
        for (int w = 0; w < 4; w++) begin
          wr(2'd0, d); wr(2'd1, w); wr(2'd2, (sel << 1) | 1);
          cyc(2);
          clear_mon();
          fire();
          cyc(3);
          for (int e = 1; e <= d + w + 2; e++) begin
            ext_edge();
            if (w > 0 && (e == 1 || e == d + 1)) retrig();
          end
          cyc(6);
          chk(rise_cnt == (w > 0 ? 1 : 0), "R8 ext single pulse", rise_cnt, w > 0);
          chk(fall_cnt == rise_cnt, "R6 ext fall count", fall_cnt, rise_cnt);
          if (w > 0) begin
            chk(rise_e == d + 1, "R4 ext delay edges R7", rise_e, d + 1);
            chk(fall_e == d + 1 + w, "R5 ext width edges", fall_e, d + 1 + w);
          end
          chk_irq(sel, w, "ext");
        end

    // R9: rewrite delay and width mid-run
    wr(2'd0, 2); wr(2'd1, 2); wr(2'd2, (1 << 1) | 1);
    cyc(2);
    clear_mon();
    fire();
    cyc(3);
    ext_edge();
    wr(2'd0, 0); wr(2'd1, 5);
    for (int e = 2; e <= 7; e++) ext_edge();
    cyc(6);
    chk(rise_e == 3, "R9 latched delay", rise_e, 3);
    chk(fall_e == 5, "R9 latched width", fall_e, 5);
    chk(irq_cnt == 1 && irq_at == rise_at, "R9 R10 rise irq", irq_at, rise_at);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule